// File: doc/BRIEF.md
# One-Wire ROM Search Triplet Unit

This block carries out a single decision step of the one-wire ROM search. After it accepts a request, it runs two read time slots on the bus. The first returns the device ID bit and the second returns its complement. From that pair the unit picks a search direction and then writes the chosen bit back with a write time slot. The caller supplies a preferred direction. The unit uses it only when both read bits are 0, which means devices on the bus disagree at this position. When both read bits are 1, no device answered, so the unit skips the write slot and reports a restart code.

The unit has its own slot timer. This timer drives an open-drain pull-low output and samples the bus level at a fixed point in each read slot. All slot timings are parameters counted in clock cycles. They must satisfy LOW1 < SAMPLE < SLOT-1 and LOW0 < SLOT.

The request side uses a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on the clock edge where both `req_valid` and `req_ready` are high. While a step runs, `req_ready` stays low, so a waiting request is held off until the step ends. The result side is a plain one-cycle `done` strobe with a 3-bit `status` word. The status word holds its value until the next step completes.

The outer search loop is not part of this block. That loop tracks the last discrepancy and assembles the 64-bit code.

Top module: `owt_triplet`

## Requirements
- R1: After a request is accepted, the first two bus slots are read slots. Each holds the bus low for LOW1 cycles. The first supplies the ID bit and the second the complement bit.
- R2: When both read bits are 1, status is 3, no third slot is driven, and `done` is asserted 2*SLOT+1 cycles after the accepting edge.
- R3: When both read bits are 0, the written bit equals the latched preferred direction. Status is 4 when that direction is 1 and 0 otherwise.
- R4: When exactly one read bit is 1, the written bit equals the ID bit. Status is 5 when the ID bit is 1 and 2 otherwise.
- R5: In the status word, bit 0 carries the ID bit, bit 1 the complement bit, and bit 2 the direction taken. The value 3 is reserved for the no-response case.
- R6: `done` is a single-cycle pulse. For a step that writes, it rises 3*SLOT+1 cycles after the accepting edge, which is after the write slot has completed.
- R7: The preferred direction is captured on the accepting edge. Changing `req_dir` afterwards has no effect on the written bit or on the status.
- R8: After reset, `req_ready` is 1, `done` is 0 and the bus is released. `req_ready` drops on the cycle after a request is accepted and stays low until `done`.
- R9: A write slot holds the bus low for LOW1 cycles when writing 1 and for LOW0 cycles when writing 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Step request valid |
| req_ready | output | 1 | Unit idle and able to accept a step |
| req_dir | input | 1 | Preferred direction, used when both read bits are 0 |
| done | output | 1 | One-cycle strobe at the end of a step |
| status | output | 3 | {direction, complement bit, ID bit}, or 3 for no response |
| bus_in | input | 1 | Sensed bus level |
| bus_pull_low | output | 1 | Drives the open-drain bus low when 1 |

## Verification
The bench builds the unit with LOW1=2, LOW0=5, SAMPLE=3 and SLOT=8. With these values one step lasts at most 25 cycles, so every combination of ID bit, complement bit and preferred direction can be run. Each combination is run twice: once with `req_dir` held steady and once with it flipped right after acceptance. A bus-device model answers each read slot. The bench counts the slots and the low cycles of each slot, which is enough to tell a read slot, a write-1 slot and a write-0 slot apart. It checks each step's latency against 2*SLOT+1 or 3*SLOT+1.

// File: rtl/owt_pkg.sv
package owt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID   = 2'd1,
    ST_CMP  = 2'd2,
    ST_WR   = 2'd3
  } trip_state_t;

  typedef struct packed {
    logic dir;
    logic cmp;
    logic id;
  } trip_status_t;

  localparam logic [2:0] NO_RESPONSE = 3'd3;
endpackage

// File: rtl/owt_slot_engine.sv
module owt_slot_engine #(
  parameter int LOW1_CYC   = 6,
  parameter int LOW0_CYC   = 60,
  parameter int SAMPLE_CYC = 15,
  parameter int SLOT_CYC   = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic is_write,
  input  logic wbit,
  input  logic bus_in,
  output logic bus_pull_low,
  output logic slot_end,
  output logic rbit
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] L1  = CW'(LOW1_CYC);
  localparam logic [CW-1:0] L0  = CW'(LOW0_CYC);
  localparam logic [CW-1:0] SMP = CW'(SAMPLE_CYC);
  localparam logic [CW-1:0] LST = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          busy;
  logic          short_q;
  logic          rbit_q;
  logic [CW-1:0] low_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      short_q <= 1'b1;
      rbit_q  <= 1'b1;
    end else begin
      if (go) begin
        busy    <= 1'b1;
        cnt     <= '0;
        short_q <= !is_write || wbit;
      end else if (busy) begin
        if (cnt == LST) busy <= 1'b0;
        else            cnt  <= cnt + 1'b1;
      end
      if (busy && cnt == SMP) rbit_q <= bus_in;
    end
  end

  always_comb begin
    low_len      = short_q ? L1 : L0;
    bus_pull_low = busy && (cnt < low_len);
    slot_end     = busy && (cnt == LST);
    rbit         = rbit_q;
  end
endmodule

// File: rtl/owt_decide.sv
module owt_decide
  import owt_pkg::*;
(
  input  logic         id_bit,
  input  logic         cmp_bit,
  input  logic         pref,
  output logic         take_dir,
  output logic         abort,
  output trip_status_t code
);
  always_comb begin
    abort    = id_bit && cmp_bit;
    take_dir = (id_bit == cmp_bit) ? pref : id_bit;
    if (abort) code = trip_status_t'(NO_RESPONSE);
    else       code = '{dir: take_dir, cmp: cmp_bit, id: id_bit};
  end
endmodule

// File: rtl/owt_triplet.sv
module owt_triplet
  import owt_pkg::*;
#(
  parameter int LOW1_CYC   = 6,
  parameter int LOW0_CYC   = 60,
  parameter int SAMPLE_CYC = 15,
  parameter int SLOT_CYC   = 70
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_dir,
  output logic       done,
  output logic [2:0] status,
  input  logic       bus_in,
  output logic       bus_pull_low
);
  trip_state_t  state;
  logic         pref_q, id_q, done_q;
  trip_status_t pend_q, status_q;
  logic         slot_end, rbit, go, go_wr, hs;
  logic         take_dir, abort;
  trip_status_t code;

  owt_slot_engine #(
    .LOW1_CYC(LOW1_CYC), .LOW0_CYC(LOW0_CYC),
    .SAMPLE_CYC(SAMPLE_CYC), .SLOT_CYC(SLOT_CYC)
  ) u_slot (
    .clk(clk), .rst_n(rst_n), .go(go), .is_write(go_wr), .wbit(take_dir),
    .bus_in(bus_in), .bus_pull_low(bus_pull_low), .slot_end(slot_end), .rbit(rbit)
  );

  owt_decide u_dec (
    .id_bit(id_q), .cmp_bit(rbit), .pref(pref_q),
    .take_dir(take_dir), .abort(abort), .code(code)
  );

  always_comb begin
    hs    = req_valid && (state == ST_IDLE);
    go_wr = (state == ST_CMP) && slot_end && !abort;
    go    = hs || ((state == ST_ID) && slot_end) || go_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pref_q   <= 1'b0;
      id_q     <= 1'b0;
      done_q   <= 1'b0;
      pend_q   <= '0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (hs) begin
          pref_q <= req_dir;
          state  <= ST_ID;
        end
        ST_ID: if (slot_end) begin
          id_q  <= rbit;
          state <= ST_CMP;
        end
        ST_CMP: if (slot_end) begin
          if (abort) begin
            status_q <= code;
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            pend_q <= code;
            state  <= ST_WR;
          end
        end
        ST_WR: if (slot_end) begin
          status_q <= pend_q;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = done_q;
  assign status    = status_q;
endmodule

// File: rtl/owt_triplet_chk.sv
module owt_triplet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic [2:0] status,
  input logic       bus_pull_low
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_pull_low);
  assert_no_response_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status[0] && status[1]) |-> (status == 3'd3));
  assert_single_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status[0] != status[1])) |-> (status[2] == status[0]));
endmodule

bind owt_triplet owt_triplet_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .status(status), .bus_pull_low(bus_pull_low)
);

// File: tb/owt_triplet_bench.sv
module owt_triplet_bench;
  localparam int L1 = 2, L0 = 5, SMP = 3, SL = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_dir = 1'b0;
  logic req_ready, done, bus_pull_low, bus_in;
  logic [2:0] status;
  logic resp_id = 1'b1, resp_cmp = 1'b1, clr = 1'b0, prev_low = 1'b0;
  int slot_idx = 0, low1 = 0, low2 = 0, low3 = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  owt_triplet #(.LOW1_CYC(L1), .LOW0_CYC(L0), .SAMPLE_CYC(SMP), .SLOT_CYC(SL)) u_owt_triplet (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dir(req_dir), .done(done), .status(status),
    .bus_in(bus_in), .bus_pull_low(bus_pull_low)
  );

  assign bus_in = !(bus_pull_low || (slot_idx == 1 && !resp_id) || (slot_idx == 2 && !resp_cmp));

  always @(negedge clk) begin
    if (clr) begin
      slot_idx <= 0; low1 <= 0; low2 <= 0; low3 <= 0; prev_low <= 1'b0;
    end else begin
      prev_low <= bus_pull_low;
      if (bus_pull_low) begin
        if (!prev_low) begin
          slot_idx <= slot_idx + 1;
          if (slot_idx == 0) low1 <= low1 + 1;
          else if (slot_idx == 1) low2 <= low2 + 1;
          else low3 <= low3 + 1;
        end else begin
          if (slot_idx == 1) low1 <= low1 + 1;
          else if (slot_idx == 2) low2 <= low2 + 1;
          else low3 <= low3 + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_step(input bit id, input bit cmp, input bit pref, input bit flip);
    bit abort, dir;
    int exp_code, n;
    abort = id && cmp;
    dir = (id == cmp) ? pref : id;
    exp_code = abort ? 3 : (int'(dir) * 4 + int'(cmp) * 2 + int'(id));
    @(negedge clk); #1;
    resp_id = id; resp_cmp = cmp; clr = 1'b1;
    @(negedge clk); #1;
    clr = 1'b0; req_valid = 1'b1; req_dir = pref;
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 1'b0;
    if (flip) req_dir = ~pref;
    check(req_ready == 1'b0, "R8 ready low while busy", int'(req_ready), 0);
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk); #1;
      n++;
    end
    check(n == (abort ? 2*SL+1 : 3*SL+1), abort ? "R2 latency" : "R6 latency",
          n, abort ? 2*SL+1 : 3*SL+1);
    if (abort) check(int'(status) == exp_code, "R2 status", int'(status), exp_code);
    else if (id == cmp) check(int'(status) == exp_code, flip ? "R7 R3 status" : "R3 status",
                              int'(status), exp_code);
    else check(int'(status) == exp_code, "R4 R5 status", int'(status), exp_code);
    check(slot_idx == (abort ? 2 : 3), "R2 slot count", slot_idx, abort ? 2 : 3);
    check(low1 == L1 && low2 == L1, "R1 read slot low time", low1 * 100 + low2, L1 * 101);
    if (!abort) check(low3 == (dir ? L1 : L0), flip ? "R7 R9 write low time" : "R9 write low time",
                      low3, dir ? L1 : L0);
    @(negedge clk); #1;
    check(done == 1'b0 && req_ready == 1'b1, "R6 done single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(req_ready == 1'b1 && done == 1'b0 && bus_pull_low == 1'b0, "R8 reset state",
          int'({req_ready, done, bus_pull_low}), 4);
    rst_n = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int k = 0; k < 8; k++)
        run_step(k[2], k[1], k[0], f[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule